// File: doc/BRIEF.md
# Third-Order Multibit Noise-Shaping Modulator

This block converts an oversampled, high-resolution signed PCM stream into a 15-level code stream whose quantization error is pushed out of the audio band by a third-order loop. The loop is a chain of three delaying integrators. The input enters only the first integrator, and the quantized output is fed back with a subtraction at the input of every integrator. Every loop gain is a sum of arithmetic right shifts, so the datapath uses only adders.

Each of the three integrators saturates at the limits of its own signed width rather than wrapping around. A uniform 15-level quantizer, with levels at k/7 of full scale, rounds the third integrator plus a dither term. It feeds back the chosen level and registers an unsigned 4-bit code. A clock enable paces the loop at the oversampled rate. A shaped dither word from outside is added at the quantizer input, and holding the dither word at zero turns dither off.

Top module: `sdm_mod3`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the code output is 7 and the loop state is cleared.
- R2: With the clock enable low, the code output and all loop state hold, and the values on the input word and the dither word have no effect.
- R3: Each enabled cycle quantizes y = third integrator + (dither << 16). The result is k = y / 1198373 rounded to the nearest integer and clamped to -7..+7, where 1198373 is 2^23/7 rounded and full scale is 2^23 input LSBs. The code is k+7, so it always lies in 0..14.
- R4: With zero input, zero dither and a cleared state, the code is 7 on every cycle.
- R5: For a constant positive input X, the long-run mean code is 7 + 0.8·X/1198373. The ratio 0.8 is the input gain 0.25 divided by the first feedback gain 0.3125.
- R6: Negative inputs give the mirror-image mean, which lies below 7 by the same formula.
- R7: Dither acts at the quantizer input. From a cleared state, the very first enabled code depends on the dither word alone.
- R8: The integrators saturate instead of wrapping. A full-scale input keeps the code inside 0..14, and after the input returns to zero the mean code returns to 7.
- R9: The code is registered. It changes on the clock edge that samples an enabled cycle and is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable at the oversampled rate |
| din | input | IN_W (24) | Signed input sample, full scale 2^23 |
| dither | input | DITH_W (8) | Signed dither word, added shifted left by DITH_SH (16) |
| code | output | 4 | Unsigned quantizer code 0..14, 7 = mid level |

## Verification
The no-wrap property on the first integrator assumes that the input and the feedback together move that integrator by less than a quarter of its range per cycle. This holds for any 24-bit input with the default 28-bit integrator. The rest-state property assumes that a cleared loop sees exactly zero input and zero dither. The bench drives only legal 24-bit and 8-bit words. Its dither patterns start from a freshly cleared state, so each first code has a known value. Its DC runs stay at or below 0.6 of full scale, apart from one deliberate full-scale overload that exercises saturation and recovery.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int CODE_W   = 4;
  localparam int N_STEPS  = 7;
  localparam int CODE_MID = N_STEPS;
  localparam int CODE_MAX = 2 * N_STEPS;

  typedef logic [CODE_W-1:0] code_t;

  // one quantizer step in internal LSBs: full scale / 7, rounded
  function automatic longint level_step(input int frac_bits);
    return ((longint'(1) <<< frac_bits) + N_STEPS / 2) / N_STEPS;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdm_gain.sv
// Constant gain as a sum of arithmetic right shifts; MASK bit i adds din >>> i.
module sdm_gain #(
  parameter int W    = 30,
  parameter int NSH  = 8,
  parameter int MASK = 1
) (
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] term [NSH];

  for (genvar i = 0; i < NSH; i++) begin : g_term
    if (MASK[i]) begin : g_on
      assign term[i] = din >>> i;
    end else begin : g_off
      assign term[i] = '0;
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < NSH; i++) dout = dout + term[i];
  end
endmodule

// File: rtl/sdm_integ.sv
// Delaying integrator: acc <= sat(acc + add_i - sub_i) on enabled cycles.
module sdm_integ #(
  parameter int W  = 28,
  parameter int OW = 30
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic signed [OW-1:0] add_i,
  input  logic signed [OW-1:0] sub_i,
  output logic signed [W-1:0]  acc_o
);
  localparam int SW = OW + 2;
  localparam logic signed [SW-1:0] HI = SW'((longint'(1) <<< (W - 1)) - 1);
  localparam logic signed [SW-1:0] LO = -HI - SW'(1);

  logic signed [SW-1:0] sum;
  logic signed [W-1:0]  nxt;

  always_comb begin
    sum = SW'(acc_o) + SW'(add_i) - SW'(sub_i);
    if (sum > HI)      nxt = HI[W-1:0];
    else if (sum < LO) nxt = LO[W-1:0];
    else               nxt = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_o <= '0;
    else if (ce) acc_o <= nxt;
  end
endmodule

// File: rtl/sdm_quant.sv
// 15-level uniform quantizer built as a ladder of 7 positive and 7 negative thresholds.
module sdm_quant
  import sdm_pkg::*;
#(
  parameter int     W   = 30,
  parameter longint LVL = 1198373
) (
  input  logic signed [W-1:0] y,
  output code_t               code,
  output logic signed [W-1:0] level
);
  localparam int DW = W + 1;

  logic signed [DW-1:0] y2;
  logic [N_STEPS-1:0] up, dn;
  logic signed [CODE_W:0] k;
  logic signed [W-1:0]    k_ext;
  localparam logic signed [W-1:0] LVL_S = W'(LVL);

  assign y2 = {y, 1'b0};

  for (genvar j = 1; j <= N_STEPS; j++) begin : g_thr
    localparam logic signed [DW-1:0] T = DW'((2 * j - 1) * LVL);
    assign up[j-1] = (y2 >= T);
    assign dn[j-1] = (y2 <= -T);
  end

  always_comb begin
    k = '0;
    for (int j = 0; j < N_STEPS; j++) begin
      k = k + (CODE_W+1)'(up[j]) - (CODE_W+1)'(dn[j]);
    end
    code  = CODE_W'(k + (CODE_W+1)'(CODE_MID));
    k_ext = W'(k);
    level = k_ext * LVL_S;
  end
endmodule

// File: rtl/sdm_mod3.sv
module sdm_mod3
  import sdm_pkg::*;
#(
  parameter int IN_W    = 24,
  parameter int DITH_W  = 8,
  parameter int DITH_SH = 16,
  parameter int I1_W    = 28,
  parameter int I2_W    = 28,
  parameter int I3_W    = 28,
  parameter int B1_MASK = 'b100,    // 0.25
  parameter int A1_MASK = 'b10100,  // 0.3125
  parameter int A2_MASK = 'b101,    // 1.25
  parameter int A3_MASK = 'b111     // 1.75
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic signed [IN_W-1:0]   din,
  input  logic signed [DITH_W-1:0] dither,
  output logic [CODE_W-1:0]        code
);
  localparam int     FRAC = IN_W - 1;
  localparam longint LVL  = level_step(FRAC);
  localparam int     WW   = max_int(max_int(I1_W, I2_W), max_int(I3_W, FRAC + 3)) + 2;

  logic signed [I1_W-1:0] x1_q;
  logic signed [I2_W-1:0] x2_q;
  logic signed [I3_W-1:0] x3_q;

  logic signed [WW-1:0] u_ext, b1u, v_fb, a1v, a2v, a3v, qin, x1_ext, x2_ext;
  code_t                q_code;

  assign u_ext  = WW'(din);
  assign x1_ext = WW'(x1_q);
  assign x2_ext = WW'(x2_q);
  assign qin    = WW'(x3_q) + (WW'(dither) <<< DITH_SH);

  sdm_gain #(.W(WW), .MASK(B1_MASK)) i_gain_b1 (.din(u_ext), .dout(b1u));
  sdm_gain #(.W(WW), .MASK(A1_MASK)) i_gain_a1 (.din(v_fb),  .dout(a1v));
  sdm_gain #(.W(WW), .MASK(A2_MASK)) i_gain_a2 (.din(v_fb),  .dout(a2v));
  sdm_gain #(.W(WW), .MASK(A3_MASK)) i_gain_a3 (.din(v_fb),  .dout(a3v));

  sdm_integ #(.W(I1_W), .OW(WW)) i_int1 (
    .clk(clk), .rst(rst), .ce(ce), .add_i(b1u), .sub_i(a1v), .acc_o(x1_q));
  sdm_integ #(.W(I2_W), .OW(WW)) i_int2 (
    .clk(clk), .rst(rst), .ce(ce), .add_i(x1_ext), .sub_i(a2v), .acc_o(x2_q));
  sdm_integ #(.W(I3_W), .OW(WW)) i_int3 (
    .clk(clk), .rst(rst), .ce(ce), .add_i(x2_ext), .sub_i(a3v), .acc_o(x3_q));

  sdm_quant #(.W(WW), .LVL(LVL)) i_quant (.y(qin), .code(q_code), .level(v_fb));

  always_ff @(posedge clk) begin
    if (rst)     code <= CODE_W'(CODE_MID);
    else if (ce) code <= q_code;
  end
endmodule

// File: rtl/sdm_mod3_chk.sv
module sdm_mod3_chk #(
  parameter int IN_W   = 24,
  parameter int DITH_W = 8,
  parameter int I1_W   = 28,
  parameter int I2_W   = 28,
  parameter int I3_W   = 28
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ce,
  input logic signed [IN_W-1:0]   din,
  input logic signed [DITH_W-1:0] dither,
  input logic [3:0]               code,
  input logic signed [I1_W-1:0]   x1,
  input logic signed [I2_W-1:0]   x2,
  input logic signed [I3_W-1:0]   x3
);
  localparam logic signed [I1_W-1:0] Q1 = I1_W'(longint'(1) <<< (I1_W - 2));

  p_reset_mid_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (code == 4'd7) && (x1 == 0) && (x2 == 0) && (x3 == 0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(code) && $stable(x1) && $stable(x2) && $stable(x3));

  p_code_range_r3: assert property (@(posedge clk) disable iff (rst)
    code <= 4'd14);

  p_zero_rest_r4: assert property (@(posedge clk) disable iff (rst)
    ce && (din == 0) && (dither == 0) && (x1 == 0) && (x2 == 0) && (x3 == 0)
    |=> (code == 4'd7) && (x1 == 0) && (x2 == 0) && (x3 == 0));

  p_no_wrap_hi_r8: assert property (@(posedge clk) disable iff (rst)
    ce && (x1 >= Q1) |=> (x1 > 0));

  p_no_wrap_lo_r8: assert property (@(posedge clk) disable iff (rst)
    ce && (x1 <= -Q1) |=> (x1 < 0));
endmodule

bind sdm_mod3 sdm_mod3_chk #(
  .IN_W(IN_W), .DITH_W(DITH_W), .I1_W(I1_W), .I2_W(I2_W), .I3_W(I3_W)
) i_sdm_mod3_chk (
  .clk(clk), .rst(rst), .ce(ce), .din(din), .dither(dither), .code(code),
  .x1(x1_q), .x2(x2_q), .x3(x3_q));

// File: tb/test_sdm_mod3.sv
module test_sdm_mod3;
  localparam real LVL = 1198373.0;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce  = 1'b0;
  logic signed [23:0] din = '0;
  logic signed [7:0]  dither = '0;
  logic [3:0]         code;

  int n_checks = 0;
  int n_errors = 0;
  logic [3:0] rec [0:99];

  always #5 clk = ~clk;

  sdm_mod3 i_sdm_mod3 (.clk(clk), .rst(rst), .ce(ce), .din(din), .dither(dither), .code(code));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_mean(input string req, input real act, input real exp, input real tol);
    n_checks++;
    if ((act - exp > tol) || (exp - act > tol)) begin
      n_errors++;
      $display("FAIL %s: actual mean=%f expected mean=%f", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ce = 1'b0; din = '0; dither = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  function automatic int exp_code(input int d);
    real r = d * 65536.0 / LVL;
    int k = (r >= 0.0) ? int'($floor(r + 0.5)) : -int'($floor(-r + 0.5));
    if (k > 7) k = 7;
    if (k < -7) k = -7;
    return k + 7;
  endfunction

  // R1: reset state
  task automatic t_reset_state();
    do_reset();
    check(code == 4'd7, "R1 reset code", code, 7);
  endtask

  // R3, R7, R9: first enabled code after reset depends on dither alone
  task automatic t_dither_levels();
    int dv [7] = '{20, -20, 127, -128, 9, 10, 60};
    foreach (dv[i]) begin
      do_reset();
      dither = 8'(dv[i]);
      tick();
      check(code == 4'd7, "R2 dither ignored with ce low", code, 7);
      ce = 1'b1;
      tick();
      check(code == 4'(exp_code(dv[i])), "R3/R7/R9 first code from dither", code, exp_code(dv[i]));
      ce = 1'b0;
    end
  endtask

  // R2: pausing with ce low, under changing inputs, leaves the code sequence intact
  task automatic t_hold();
    int mism = 0;
    do_reset();
    din = 24'sd3000000; ce = 1'b1;
    for (int i = 0; i < 100; i++) begin tick(); rec[i] = code; end
    do_reset();
    din = 24'sd3000000; ce = 1'b1;
    for (int i = 0; i < 50; i++) begin tick(); if (code != rec[i]) mism++; end
    ce = 1'b0;
    for (int i = 0; i < 7; i++) begin
      din = 24'(-5000000 + i * 1000000); dither = 8'(i * 30 - 90);
      tick();
      if (code != rec[49]) mism++;
    end
    din = 24'sd3000000; dither = '0; ce = 1'b1;
    for (int i = 50; i < 100; i++) begin tick(); if (code != rec[i]) mism++; end
    check(mism == 0, "R2 hold with ce low", mism, 0);
  endtask

  // R4: zero input, zero dither
  task automatic t_zero();
    int bad = 0;
    do_reset();
    ce = 1'b1;
    for (int i = 0; i < 256; i++) begin tick(); if (code != 4'd7) bad++; end
    check(bad == 0, "R4 zero input gives constant mid code", bad, 0);
  endtask

  // R5, R6: DC mean
  task automatic t_dc(input int x, input string req);
    longint acc = 0;
    int rng_bad = 0;
    do_reset();
    din = 24'(x); ce = 1'b1;
    for (int i = 0; i < 1024; i++) tick();
    for (int i = 0; i < 8192; i++) begin
      tick();
      acc += code;
      if (code > 4'd14) rng_bad++;
    end
    check(rng_bad == 0, "R3 code range", rng_bad, 0);
    check_mean(req, real'(acc) / 8192.0, 7.0 + 0.8 * x / LVL, 0.05);
  endtask

  // R8: full-scale overload and recovery
  task automatic t_overload();
    longint acc = 0;
    int rng_bad = 0;
    do_reset();
    din = 24'sh7fffff; ce = 1'b1;
    for (int i = 0; i < 3000; i++) begin tick(); if (code > 4'd14) rng_bad++; end
    din = 24'sh800000;
    for (int i = 0; i < 3000; i++) begin tick(); if (code > 4'd14) rng_bad++; end
    check(rng_bad == 0, "R8 code in range under overload", rng_bad, 0);
    din = '0;
    for (int i = 0; i < 3000; i++) tick();
    for (int i = 0; i < 8192; i++) begin tick(); acc += code; end
    check_mean("R8 recovery to mid mean", real'(acc) / 8192.0, 7.0, 0.1);
  endtask

  initial begin
    t_reset_state();
    t_dither_levels();
    t_hold();
    t_zero();
    t_dc(4194304,  "R5 mean for +0.5 input");
    t_dc(5033165,  "R5 mean for +0.6 input");
    t_dc(-4194304, "R6 mean for -0.5 input");
    t_dc(838860,   "R5 mean for +0.1 input");
    t_overload();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #1500000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule